// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host read and write an external asynchronous static RAM of 256K words by 8 bits. The host presents an address, write data and a write flag together with a request strobe. The controller accepts the request when it is idle and raises `busy_o` while it works. It then runs the memory pins through a fixed sequence of phases. Each phase lasts a whole number of clock cycles, and that number comes from the memory's minimum timings in nanoseconds and the clock period.

Writes are WE-controlled. The chip is selected, the address and data are presented, and WE is pulsed low. WE rises while the chip is still selected and the data is still driven, so the data hold is always met. Reads hold the chip selected with OE low for the whole access window and sample the data bus on the last cycle of that window. After the sample, a one-cycle valid pulse and the captured byte go to the host. After every read, the controller keeps its own data drivers off for a turnaround gap, so the memory has time to release the bus. When no access is in progress, the memory is deselected and sits in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `busy_o` is low, the memory is deselected (`mem_ce1_n_o`=1, `mem_ce2_o`=0), `mem_we_n_o`=1, `mem_oe_n_o`=1 and `mem_dq_oe_o`=0.
- R2: `mem_we_n_o` goes low only while the chip is selected, OE is high and the controller drives data. Each low pulse lasts exactly the write-pulse count of cycles (5 at the defaults).
- R3: During a write, address and data are presented one cycle before WE falls and stay stable until WE rises. They remain driven for the cycle after WE rises.
- R4: A write keeps `busy_o` high for setup + pulse + end cycles (1 + 5 + 1 = 7 at the defaults), then returns to idle.
- R5: A read holds the chip selected with OE low and WE high for the access count of cycles (7 at the defaults). `rvalid_o` is high for exactly one cycle, the cycle after the last access cycle. `rdata_o` then holds the captured byte until the next read.
- R6: After a read, the controller stays busy and deselected for the turnaround count (3 at the defaults), so a read keeps `busy_o` high for 10 cycles.
- R7: `mem_dq_oe_o` is never high while `mem_oe_n_o` is low. It rises only after OE has been high for at least the turnaround count of cycles.
- R8: A request is accepted only while `busy_o` is low. A request raised while busy, of either kind, has no effect on memory contents.
- R9: A read returns the byte most recently written to the same address.
- R10: Each cycle count is the ceiling of its nanosecond minimum divided by `CLK_PERIOD_NS`, with a floor of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, taken while not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 8 | Last byte read |
| rvalid_o | output | 1 | One-cycle pulse: `rdata_o` updated |
| mem_addr_o | output | 18 | Memory address pins |
| mem_ce1_n_o | output | 1 | Active-low chip select |
| mem_ce2_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe_o | output | 1 | Enable for the data pad drivers |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The pin assertions need nothing from the host. They do assume the memory follows its own output-release limit after OE rises, which the R7 gap checker models in cycles. The bench behaves as a well-behaved host: it drives requests on falling edges and waits for `busy_o` to fall before it issues the next one. The one exception is a deliberate request during a write, which R8 says must be ignored. The bench's memory model returns corrupted data if sampled before the access and OE minimums have elapsed. It also flags pulse-width, setup and contention violations in nanoseconds, so timing errors show up as wrong read data or model failures.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and cycle-count arithmetic for the SRAM controller.
// Assumes timings and clock period are given in whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_TURNAROUND
    } seq_state_e;

    // Ceiling division of a nanosecond minimum by the clock period.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Module: phase down-counter. Loaded with (length - 1) on entry to a phase,
// counts down to zero; expired_o marks the last cycle of the phase.
// Assumes load_i is a single-cycle strobe coinciding with a state change.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_m1_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_m1_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Module: access sequencer. Steps through write or read phases, asks the
// timer for each phase length, and registers the memory control levels from
// the next state so the pins change cleanly on a clock edge.
// Assumes every phase length parameter is at least 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned PULSE_CYC = 5,
    parameter int unsigned END_CYC   = 1,
    parameter int unsigned ACC_CYC   = 7,
    parameter int unsigned TURN_CYC  = 3,
    parameter int unsigned CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic             expired_i,
    output logic             timer_load_o,
    output logic [CNT_W-1:0] timer_len_m1_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             busy_o,
    output logic             sel_o,
    output logic             we_n_o,
    output logic             oe_n_o,
    output logic             drive_o
);

    localparam int unsigned ACC_MAIN_CYC = ACC_CYC - 1;

    seq_state_e state_q, state_d;
    logic       sel_q, we_n_q, oe_n_q, drive_q;

    // Length of each phase minus one, as loaded into the timer.
    function automatic logic [CNT_W-1:0] phase_len_m1(input seq_state_e st);
        case (st)
            ST_WR_SETUP:   return CNT_W'(SETUP_CYC - 1);
            ST_WR_PULSE:   return CNT_W'(PULSE_CYC - 1);
            ST_WR_END:     return CNT_W'(END_CYC - 1);
            ST_RD_ACCESS:  return CNT_W'(ACC_MAIN_CYC - 1);
            ST_RD_CAPTURE: return '0;
            ST_TURNAROUND: return CNT_W'(TURN_CYC - 1);
            default:       return '0;
        endcase
    endfunction

    // Next-state selection: leave a phase when its timer has expired.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = we_i ? ST_WR_SETUP : ST_RD_ACCESS;
                end
            end
            ST_WR_SETUP:   if (expired_i) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired_i) state_d = ST_WR_END;
            ST_WR_END:     if (expired_i) state_d = ST_IDLE;
            ST_RD_ACCESS:  if (expired_i) state_d = ST_RD_CAPTURE;
            ST_RD_CAPTURE: if (expired_i) state_d = ST_TURNAROUND;
            ST_TURNAROUND: if (expired_i) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pin levels, decoded from the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            drive_q <= 1'b0;
        end else begin
            sel_q   <= (state_d != ST_IDLE) && (state_d != ST_TURNAROUND);
            we_n_q  <= (state_d != ST_WR_PULSE);
            oe_n_q  <= !((state_d == ST_RD_ACCESS) || (state_d == ST_RD_CAPTURE));
            drive_q <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                       (state_d == ST_WR_END);
        end
    end

    assign timer_load_o   = (state_d != state_q);
    assign timer_len_m1_o = phase_len_m1(state_d);
    assign accept_o       = (state_q == ST_IDLE) && req_i;
    assign capture_o      = (state_q == ST_RD_CAPTURE);
    assign busy_o         = (state_q != ST_IDLE);
    assign sel_o          = sel_q;
    assign we_n_o         = we_n_q;
    assign oe_n_o         = oe_n_q;
    assign drive_o        = drive_q;

endmodule

// File: rtl/sram_bus_regs.sv
`timescale 1ns/1ps
// Module: host-side data path. Latches address and write byte when a request
// is accepted, and samples the memory data bus on the capture cycle.
// Assumes accept_i and capture_i are never high in the same cycle.
module sram_bus_regs #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rvalid_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Sample read data on the final access cycle and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture_i;
            if (capture_i) begin
                rdata_q <= mem_dq_i;
            end
        end
    end

    assign addr_o   = addr_q;
    assign wdata_o  = wdata_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Module: top of the asynchronous SRAM controller. Converts nanosecond
// minimums into cycle counts and wires sequencer, timer and data path.
// Assumes the pad drivers for mem_dq_o are enabled by mem_dq_oe_o outside.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_PWE_NS      = 50,
    parameter int unsigned T_SD_NS       = 30,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_DOE_NS      = 35,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_REL_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce1_n_o,
    output logic              mem_ce2_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned SETUP_CYC = 1;
    localparam int unsigned PULSE_CYC = max_u(max_u(1, ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS)),
                                        max_u(ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)) - SETUP_CYC);
    localparam int unsigned END_CYC   = max_u(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS)
                                                 - SETUP_CYC - PULSE_CYC);
    localparam int unsigned ACC_CYC   = max_u(2, max_u(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                        max_u(ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_RC_NS, CLK_PERIOD_NS))));
    localparam int unsigned TURN_CYC  = max_u(1, ns_to_cyc(T_REL_NS, CLK_PERIOD_NS));
    localparam int unsigned MAX_CYC   = max_u(max_u(PULSE_CYC, END_CYC), max_u(ACC_CYC, TURN_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    logic             timer_load, timer_expired, accept, capture, sel;
    logic [CNT_W-1:0] timer_len_m1;

    sram_seq_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .END_CYC   (END_CYC),
        .ACC_CYC   (ACC_CYC),
        .TURN_CYC  (TURN_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .we_i           (we_i),
        .expired_i      (timer_expired),
        .timer_load_o   (timer_load),
        .timer_len_m1_o (timer_len_m1),
        .accept_o       (accept),
        .capture_o      (capture),
        .busy_o         (busy_o),
        .sel_o          (sel),
        .we_n_o         (mem_we_n_o),
        .oe_n_o         (mem_oe_n_o),
        .drive_o        (mem_dq_oe_o)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .len_m1_i  (timer_len_m1),
        .expired_o (timer_expired)
    );

    sram_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .capture_i (capture),
        .mem_dq_i  (mem_dq_i),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_dq_o),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    // Both selects come from one flop so they can never disagree.
    assign mem_ce1_n_o = ~sel;
    assign mem_ce2_o   = sel;

endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
// Module: pin-level protocol checker for sram_async_ctrl, attached by bind.
// Assumes the cycle-count parameters match those of the bound instance.
module sram_ctrl_checker #(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_CYC = 5,
    parameter int unsigned TURN_CYC  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              rvalid_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ce1_n_o,
    input logic              mem_ce2_o,
    input logic              mem_we_n_o,
    input logic              mem_oe_n_o,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe_o
);

    logic [7:0] oe_high_cnt;
    logic [7:0] we_low_cnt;

    // Consecutive cycles with OE high (saturating) and with WE low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_high_cnt <= 8'hFF;
            we_low_cnt  <= 8'd0;
        end else begin
            oe_high_cnt <= mem_oe_n_o ? ((oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 8'd1) : 8'd0;
            we_low_cnt  <= mem_we_n_o ? 8'd0 : we_low_cnt + 8'd1;
        end
    end

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_ce1_n_o && !mem_ce2_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o)); // R1
    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_ce1_n_o && mem_ce2_o && mem_oe_n_o && mem_dq_oe_o)); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_low_cnt == 8'(PULSE_CYC))); // R2
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_dq_o) && $stable(mem_addr_o))); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_ce1_n_o)); // R3
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o); // R5
    AST_RVALID_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (busy_o && mem_ce1_n_o && mem_oe_n_o)); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o); // R7
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (oe_high_cnt >= 8'(TURN_CYC))); // R7

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .rvalid_o    (rvalid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce1_n_o (mem_ce1_n_o),
    .mem_ce2_o   (mem_ce2_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
// Bench: host sweeps plus a timed behavioural memory model.
module test_sram_async_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    // Expected cycle counts, R10: ceil(ns / period), floor 1.
    localparam int EXP_PULSE  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_ACC    = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_TURN   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WR     = 1 + EXP_PULSE + 1;
    localparam int EXP_RD     = EXP_ACC + EXP_TURN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, rvalid, ce1_n, ce2, we_n, oe_n, dq_oe;
    logic [7:0]  rdata, dq_out;
    logic [7:0]  dq_in = '0;
    logic [17:0] mem_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [7:0] ref_mem   [int];
    logic [7:0] model_mem [int];

    realtime t_acc = 0, t_oe_fall = 0, t_oe_rise = -1000, t_we_fall = 0, t_dq = 0, t_addr = 0;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(mem_addr),
        .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
        .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
    );

    always #(HALF) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    always @(mem_addr) t_addr = $realtime;
    always @(mem_addr, ce1_n, ce2) t_acc = $realtime;
    always @(negedge oe_n) t_oe_fall = $realtime;
    always @(posedge oe_n) t_oe_rise = $realtime;
    always @(negedge we_n) t_we_fall = $realtime;
    always @(dq_out, dq_oe) t_dq = $realtime;

    // Write ends on WE rise: check timing minimums in ns, then store (R2, R3).
    always @(posedge we_n) begin
        if (rst_n) begin
            chk(($realtime - t_we_fall) >= 50.0, "R2 model WE width", longint'($realtime - t_we_fall), 50);
            chk(($realtime - t_dq) >= 30.0 && dq_oe, "R3 model data setup", longint'($realtime - t_dq), 30);
            chk(($realtime - t_addr) >= 60.0, "R3 model addr setup", longint'($realtime - t_addr), 60);
            chk(!ce1_n && ce2, "R2 model selected at write end", {ce1_n, ce2}, 2'b01);
            model_mem[int'(mem_addr)] = dq_out;
        end
    end

    // Contention: drivers may turn on only after the memory has released (R7).
    always @(posedge dq_oe) begin
        if (rst_n) begin
            chk(oe_n && (($realtime - t_oe_rise) >= 25.0), "R7 model turnaround",
                longint'($realtime - t_oe_rise), 25);
        end
    end

    // Memory drive: valid only after access and OE minimums, otherwise corrupted.
    always @(negedge clk) begin
        logic [7:0] val;
        val = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        if (!ce1_n && ce2 && we_n && !oe_n) begin
            if (($realtime + HALF - t_acc) >= 70.0 && ($realtime + HALF - t_oe_fall) >= 35.0)
                dq_in <= val;
            else
                dq_in <= ~val;
        end else begin
            dq_in <= 8'h00;
        end
    end

    // ---------------- host tasks (called at a falling edge) ----------------
    task automatic check_idle(input string tag);
        chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe, tag, {ce1_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d,
                            input bit inject, input logic [17:0] ia, input bit iwe);
        int k;
        int we_cnt;
        bit dq_ok;
        we_cnt = 0;
        dq_ok = 1'b1;
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        k = 1;
        while (busy && k < 40) begin
            if (!we_n) we_cnt++;
            if (!dq_oe || dq_out !== d || mem_addr !== a) dq_ok = 1'b0;
            if (inject && k == 3) begin
                req = 1'b1; we = iwe; addr = ia; wdata = ~d;
            end
            if (k == 4) req = 1'b0;
            @(negedge clk);
            k++;
        end
        ref_mem[int'(a)] = d;
        chk(k - 1 == EXP_WR, "R4 write busy cycles", k - 1, EXP_WR);
        chk(we_cnt == EXP_PULSE, "R2 WE low cycles", we_cnt, EXP_PULSE);
        chk(dq_ok, "R3 data and address driven for whole write", dq_ok, 1);
        check_idle("R1 idle after write");
    endtask

    task automatic do_read(input logic [17:0] a);
        int k;
        int oe_cnt;
        int rv_k;
        int rv_cnt;
        bit no_drive;
        logic [7:0] exp;
        logic [7:0] got;
        oe_cnt = 0; rv_k = 0; rv_cnt = 0; no_drive = 1'b1; got = '0;
        exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        k = 1;
        while (busy && k < 40) begin
            if (!oe_n) oe_cnt++;
            if (dq_oe || !we_n) no_drive = 1'b0;
            if (rvalid) begin rv_cnt++; rv_k = k; got = rdata; end
            if (rv_k != 0 && k == rv_k + 1) begin
                chk(!rvalid && rdata == exp, "R5 rdata held, rvalid one cycle", {rvalid, rdata}, {1'b0, exp});
            end
            if (k > EXP_ACC) chk(ce1_n && !ce2 && oe_n, "R6 deselected in turnaround", {ce1_n, ce2, oe_n}, 3'b101);
            @(negedge clk);
            k++;
        end
        chk(k - 1 == EXP_RD, "R6 read busy cycles", k - 1, EXP_RD);
        chk(oe_cnt == EXP_ACC, "R5 OE low cycles", oe_cnt, EXP_ACC);
        chk(rv_cnt == 1 && rv_k == EXP_ACC + 1, "R5 rvalid timing", rv_k, EXP_ACC + 1);
        chk(no_drive, "R7 no drive and WE high during read", no_drive, 1);
        chk(got == exp, "R9 read data", got, exp);
        check_idle("R1 idle after read");
    endtask

    function automatic logic [17:0] sweep_addr(input int i);
        if (i < 18) return 18'(1) << i;
        if (i == 18) return 18'h00000;
        return 18'h3FFFF;
    endfunction

    function automatic logic [7:0] sweep_data(input int i, input int pass);
        return 8'(i * 37 + 5 + pass * 91) ^ 8'(i << 4);
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !rvalid, "R1 reset busy/rvalid", {busy, rvalid}, 0);
        check_idle("R1 reset pins");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");
        chk(EXP_PULSE == 5 && EXP_ACC == 7 && EXP_TURN == 3, "R10 derived counts",
            EXP_PULSE * 100 + EXP_ACC * 10 + EXP_TURN, 573);

        // Sweep of walking-one addresses plus both ends, write then read back.
        for (int i = 0; i < 20; i++) do_write(sweep_addr(i), sweep_data(i, 0), 1'b0, '0, 1'b0);
        for (int i = 0; i < 20; i++) do_read(sweep_addr(i));

        // Back-to-back alternating write/read with fresh data.
        for (int i = 0; i < 20; i++) begin
            do_write(sweep_addr(i), sweep_data(i, 1), 1'b0, '0, 1'b0);
            do_read(sweep_addr(i));
        end

        // Read then write straight away: turnaround before driving (R7).
        do_read(sweep_addr(5));
        do_write(sweep_addr(6), 8'hA5, 1'b0, '0, 1'b0);

        // Requests during a write must be ignored (R8).
        do_write(sweep_addr(2), 8'h3C, 1'b1, sweep_addr(3), 1'b1);
        do_read(sweep_addr(3));
        do_write(sweep_addr(4), 8'hC3, 1'b1, sweep_addr(7), 1'b0);
        chk(!busy && !rvalid, "R8 ignored request started nothing", {busy, rvalid}, 0);
        do_read(sweep_addr(4));
        do_read(sweep_addr(6));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule